// File: doc/BRIEF.md
# Register-Programmed Block Copy Engine

This block moves a run of bytes between host memory and a small buffer that lives inside the device. Software loads a source address, a destination address and a byte count into 64-bit registers, then writes a command word. The command word starts the copy, picks its direction and can ask for a completion event. The device-side address is given in device address space, where the buffer begins at a fixed offset of 0x40000.

The start bit reads back as one while the copy runs and drops to zero when the copy finishes, so a driver can poll for completion. Before any byte moves, the engine checks the request. The device range must lie wholly inside the buffer, and the host range must lie below the DMA address limit, which is 2^MASK_BITS (28 bits by default). A request that fails either check is dropped. It touches no memory and raises no event.

Host traffic goes through a plain byte-wide request/response port. Each accepted request carries exactly one byte. The buffer is an internal synchronous single-port RAM with one cycle of read latency.

Top module: `bufdma_engine`

## Requirements
- R1: After reset the source, destination, count and command registers read zero, `hst_req` is low and `irq_evt` is low.
- R2: The registers are decoded from `reg_addr` as follows: source at 0x80, destination at 0x88, count at 0x90, command at 0x98. An 8-byte access (`reg_size8`=1) covers the whole register. A 4-byte access with `reg_addr[2]`=0 covers bits 31:0, and one with `reg_addr[2]`=1 covers bits 63:32. A 4-byte write changes only its own half, and a 4-byte read returns its half in `reg_rdata[31:0]` with zeros above. In the command word, bit 0 is start, bit 1 is direction and bit 2 is the event enable.
- R3: When the direction bit is 0, a started copy moves `count` bytes from host address `src+i` to buffer byte `dst-0x40000+i`.
- R4: When the direction bit is 1, a started copy moves `count` bytes from buffer byte `src-0x40000+i` to host address `dst+i`.
- R5: Command bit 0 reads 1 from the cycle after the start write until the copy ends, and reads 0 afterwards.
- R6: When a copy completes with the event enable set, `irq_evt` pulses high for exactly one cycle and `irq_code` reads 0x100 at that moment. When the enable is clear, no pulse occurs.
- R7: A request whose device range falls outside 0x40000..0x40000+BUF_BYTES-1 makes no host request and writes no buffer byte. Its start bit clears and it raises no event. A range that ends exactly on the last buffer byte is accepted.
- R8: A request whose host range reaches 2^MASK_BITS or beyond is dropped in the same way as in R7. A range that ends on the last byte below the limit is accepted.
- R9: While a copy runs, writes to the source, destination, count and command registers have no effect.
- R10: Every host request carries one byte. A request stays asserted, with its address and direction held, until `hst_ready` accepts it. After an accepted read, the engine waits for `hst_rvalid`. The number of accepted requests equals the count.
- R11: A count of zero completes without any host traffic. It still honours the event enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 8 | register byte offset |
| reg_size8 | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| reg_wdata | input | 64 | register write data |
| reg_rdata | output | 64 | register read data (combinational) |
| hst_req | output | 1 | host byte request valid |
| hst_we | output | 1 | 1 = host write, 0 = host read |
| hst_addr | output | 64 | host byte address |
| hst_wdata | output | 8 | host write byte |
| hst_ready | input | 1 | host accepts the request |
| hst_rvalid | input | 1 | host read byte returned |
| hst_rdata | input | 8 | host read byte |
| irq_evt | output | 1 | completion event pulse |
| irq_code | output | 32 | event value, 0x100 |

## Verification
The bench builds the engine with a 64-byte buffer and a 10-bit DMA address limit. With these values the whole buffer and every host byte the engine can reach fit in a bench array, so each copy can be checked byte for byte against arithmetic expectations. The small sizes also put both range-check edges within reach: the final buffer byte and the final host byte under the limit, each hit exactly and then overshot by one. A host that stalls one cycle in three exercises the request hold and the wait for read data on every transfer.

// File: rtl/bufdma_pkg.sv
// Shared constants and state type for the block copy engine.
package bufdma_pkg;
    localparam logic [4:0] SEL_SRC = 5'h10;  // 0x80
    localparam logic [4:0] SEL_DST = 5'h11;  // 0x88
    localparam logic [4:0] SEL_CNT = 5'h12;  // 0x90
    localparam logic [4:0] SEL_CMD = 5'h13;  // 0x98
    localparam int CMD_GO  = 0;
    localparam int CMD_DIR = 1;
    localparam int CMD_IEN = 2;
    localparam logic [31:0] DONE_CODE = 32'h0000_0100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_HREQ,
        ST_HWAIT,
        ST_BRD,
        ST_HWR,
        ST_DONE
    } dma_state_t;
endpackage

// File: rtl/bufdma_ram.sv
// Buffer storage: synchronous single-port RAM, one cycle read latency.
// Assumes one access per cycle; rdata holds until the next read.
module bufdma_ram #(
    parameter int DEPTH = 4096,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Perform the single access of this cycle.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end
endmodule

// File: rtl/bufdma_regs.sv
// Register file: source, destination, count and command flags.
// Assumes accesses at 0x80 and above; writes are blocked while busy.
module bufdma_regs
    import bufdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic        reg_size8,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    input  logic        busy,
    output logic [63:0] src_q,
    output logic [63:0] dst_q,
    output logic [63:0] cnt_q,
    output logic        start_req,
    output logic        start_dir,
    output logic        start_ien
);
    logic [4:0]  sel;
    logic        hi;
    logic        dir_q, ien_q;
    logic [63:0] full;

    assign sel = reg_addr[7:3];
    assign hi  = reg_addr[2];

    // Merge write data into one 64-bit register by access size and half.
    function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] wd,
                                          input logic s8, input logic h);
        if (s8)     return wd;
        else if (h) return {wd[31:0], old[31:0]};
        else        return {old[63:32], wd[31:0]};
    endfunction

    // A command write with start set, while idle, launches a copy.
    assign start_req = reg_wr && !busy && sel == SEL_CMD && (reg_size8 || !hi) && reg_wdata[CMD_GO];
    assign start_dir = reg_wdata[CMD_DIR];
    assign start_ien = reg_wdata[CMD_IEN];

    // Register updates, ignored during a copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
            dir_q <= 1'b0;
            ien_q <= 1'b0;
        end else if (reg_wr && !busy) begin
            case (sel)
                SEL_SRC: src_q <= merge(src_q, reg_wdata, reg_size8, hi);
                SEL_DST: dst_q <= merge(dst_q, reg_wdata, reg_size8, hi);
                SEL_CNT: cnt_q <= merge(cnt_q, reg_wdata, reg_size8, hi);
                SEL_CMD: if (reg_size8 || !hi) begin
                    dir_q <= reg_wdata[CMD_DIR];
                    ien_q <= reg_wdata[CMD_IEN];
                end
                default: ;
            endcase
        end
    end

    // Read mux; the command start bit reflects the live busy flag.
    always_comb begin
        case (sel)
            SEL_SRC: full = src_q;
            SEL_DST: full = dst_q;
            SEL_CNT: full = cnt_q;
            SEL_CMD: full = {61'b0, ien_q, dir_q, busy};
            default: full = '0;
        endcase
        if (reg_size8) reg_rdata = full;
        else if (hi)   reg_rdata = {32'b0, full[63:32]};
        else           reg_rdata = {32'b0, full[31:0]};
    end
endmodule

// File: rtl/bufdma_ctrl.sv
// Copy sequencer: checks a launched request, then moves one byte per
// host handshake between the host port and the buffer RAM.
// Assumes a host read answers with hst_rvalid some cycles after acceptance.
module bufdma_ctrl
    import bufdma_pkg::*;
#(
    parameter int          BUF_BYTES = 4096,
    parameter logic [63:0] BUF_BASE  = 64'h4_0000,
    parameter int          MASK_BITS = 28,
    localparam int         BAW       = $clog2(BUF_BYTES),
    localparam int         IW        = BAW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_req,
    input  logic           start_dir,
    input  logic           start_ien,
    input  logic [63:0]    src,
    input  logic [63:0]    dst,
    input  logic [63:0]    cnt,
    output logic           busy,
    output logic           hst_req,
    output logic           hst_we,
    output logic [63:0]    hst_addr,
    input  logic           hst_ready,
    input  logic           hst_rvalid,
    output logic           ram_en,
    output logic           ram_we,
    output logic [BAW-1:0] ram_addr,
    output logic           irq_evt
);
    dma_state_t  state;
    logic [63:0] host_q, dev_q, cnt_q;
    logic [IW-1:0] idx, idx_nx;
    logic        dir_q, ien_q;
    logic [64:0] dev_rel, dev_end, host_end;
    logic        dev_ok, host_ok, last;

    // Range checks on the latched request (65-bit to avoid wrap).
    assign dev_rel  = {1'b0, dev_q} - {1'b0, BUF_BASE};
    assign dev_end  = dev_rel + {1'b0, cnt_q};
    assign host_end = {1'b0, host_q} + {1'b0, cnt_q};
    assign dev_ok   = (dev_q >= BUF_BASE) && (cnt_q <= 64'(BUF_BYTES)) && (dev_end <= 65'(BUF_BYTES));
    assign host_ok  = host_end <= (65'd1 << MASK_BITS);

    assign idx_nx = idx + 1'b1;
    assign last   = idx_nx == cnt_q[IW-1:0];

    assign busy     = state != ST_IDLE;
    assign hst_req  = state == ST_HREQ || state == ST_HWR;
    assign hst_we   = state == ST_HWR;
    assign hst_addr = host_q + {{(64-IW){1'b0}}, idx};
    assign ram_addr = dev_rel[BAW-1:0] + idx[BAW-1:0];
    assign ram_we   = state == ST_HWAIT && hst_rvalid;
    assign ram_en   = ram_we || state == ST_BRD;

    // Sequencer state, byte index and completion event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            host_q  <= '0;
            dev_q   <= '0;
            cnt_q   <= '0;
            idx     <= '0;
            dir_q   <= 1'b0;
            ien_q   <= 1'b0;
            irq_evt <= 1'b0;
        end else begin
            irq_evt <= 1'b0;
            case (state)
                ST_IDLE: if (start_req) begin
                    host_q <= start_dir ? dst : src;
                    dev_q  <= start_dir ? src : dst;
                    cnt_q  <= cnt;
                    dir_q  <= start_dir;
                    ien_q  <= start_ien;
                    idx    <= '0;
                    state  <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (!(dev_ok && host_ok)) state <= ST_IDLE;
                    else if (cnt_q == '0)     state <= ST_DONE;
                    else                      state <= dir_q ? ST_BRD : ST_HREQ;
                end
                ST_HREQ: if (hst_ready) state <= ST_HWAIT;
                ST_HWAIT: if (hst_rvalid) begin
                    idx   <= idx_nx;
                    state <= last ? ST_DONE : ST_HREQ;
                end
                ST_BRD: state <= ST_HWR;
                ST_HWR: if (hst_ready) begin
                    idx   <= idx_nx;
                    state <= last ? ST_DONE : ST_BRD;
                end
                ST_DONE: begin
                    irq_evt <= ien_q;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bufdma_engine.sv
// Top of the block copy engine: registers, sequencer and buffer RAM.
// Assumes a byte-wide host port with valid/ready requests and read replies.
module bufdma_engine
    import bufdma_pkg::*;
#(
    parameter int          BUF_BYTES = 4096,
    parameter logic [63:0] BUF_BASE  = 64'h4_0000,
    parameter int          MASK_BITS = 28,
    localparam int         BAW       = $clog2(BUF_BYTES)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [7:0]  reg_addr,
    input  logic        reg_size8,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    output logic        hst_req,
    output logic        hst_we,
    output logic [63:0] hst_addr,
    output logic [7:0]  hst_wdata,
    input  logic        hst_ready,
    input  logic        hst_rvalid,
    input  logic [7:0]  hst_rdata,
    output logic        irq_evt,
    output logic [31:0] irq_code
);
    logic [63:0]    src_w, dst_w, cnt_w;
    logic           busy_w, start_req, start_dir, start_ien;
    logic           ram_en, ram_we;
    logic [BAW-1:0] ram_addr;

    assign irq_code = DONE_CODE;

    bufdma_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_size8(reg_size8),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy_w),
        .src_q(src_w), .dst_q(dst_w), .cnt_q(cnt_w),
        .start_req(start_req), .start_dir(start_dir), .start_ien(start_ien)
    );

    bufdma_ctrl #(.BUF_BYTES(BUF_BYTES), .BUF_BASE(BUF_BASE), .MASK_BITS(MASK_BITS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .start_req(start_req), .start_dir(start_dir), .start_ien(start_ien),
        .src(src_w), .dst(dst_w), .cnt(cnt_w), .busy(busy_w),
        .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr),
        .hst_ready(hst_ready), .hst_rvalid(hst_rvalid),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .irq_evt(irq_evt)
    );

    bufdma_ram #(.DEPTH(BUF_BYTES)) u_ram (
        .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
        .wdata(hst_rdata), .rdata(hst_wdata)
    );
endmodule

// File: rtl/bufdma_chk.sv
// Protocol and ordering checks for the block copy engine, bound to the top.
module bufdma_chk #(
    parameter int MASK_BITS = 28
) (
    input logic        clk,
    input logic        rst_n,
    input logic        hst_req,
    input logic        hst_we,
    input logic [63:0] hst_addr,
    input logic        hst_ready,
    input logic        irq_evt,
    input logic        busy,
    input logic [63:0] src
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!hst_req && !irq_evt));
    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_req && !hst_ready) |=> (hst_req && $stable(hst_addr) && $stable(hst_we)));
    // R8
    host_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hst_req |-> ((hst_addr >> MASK_BITS) == 64'd0));
    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_evt |=> !irq_evt);
    // R6
    irq_after_copy_chk: assert property (@(posedge clk) disable iff (!rst_n) irq_evt |-> $past(busy));
    // R7
    idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !hst_req);
    // R9
    src_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(src));
endmodule

bind bufdma_engine bufdma_chk #(.MASK_BITS(MASK_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .hst_req(hst_req), .hst_we(hst_we),
    .hst_addr(hst_addr), .hst_ready(hst_ready), .irq_evt(irq_evt),
    .busy(busy_w), .src(src_w)
);

// File: tb/bufdma_engine_bench.sv
module bufdma_engine_bench;
    localparam int          NB   = 64;
    localparam int          MB   = 10;
    localparam int          HN   = 1 << MB;
    localparam logic [63:0] BASE = 64'h4_0000;

    logic        clk = 0, rst_n = 0;
    logic        reg_wr = 0, reg_size8 = 0;
    logic [7:0]  reg_addr = 0;
    logic [63:0] reg_wdata = 0, reg_rdata;
    logic        hst_req, hst_we, hst_ready = 0, hst_rvalid = 0;
    logic [63:0] hst_addr;
    logic [7:0]  hst_wdata, hst_rdata = 0;
    logic        irq_evt;
    logic [31:0] irq_code;

    int total = 0, bad = 0, cyc = 0, hs_cnt = 0, irq_cnt = 0, code_bad = 0;
    logic [7:0] hmem [HN];
    logic [7:0] exp_h [HN];
    logic [7:0] exp_b [NB];

    always #10 clk = ~clk;

    bufdma_engine #(.BUF_BYTES(NB), .BUF_BASE(BASE), .MASK_BITS(MB)) u_bufdma_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_size8(reg_size8), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_ready(hst_ready), .hst_rvalid(hst_rvalid), .hst_rdata(hst_rdata),
        .irq_evt(irq_evt), .irq_code(irq_code)
    );

    // Host memory model: stalls one cycle in three, read data one cycle after accept.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        hst_ready  <= (cyc % 3) != 1;
        hst_rvalid <= 1'b0;
        if (hst_req && hst_ready) begin
            hs_cnt <= hs_cnt + 1;
            if (hst_we) hmem[hst_addr[MB-1:0]] <= hst_wdata;
            else begin
                hst_rvalid <= 1'b1;
                hst_rdata  <= hmem[hst_addr[MB-1:0]];
            end
        end
        if (irq_evt) begin
            irq_cnt <= irq_cnt + 1;
            if (irq_code != 32'h100) code_bad <= code_bad + 1;
        end
    end

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d, input logic s8);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d; reg_size8 = s8;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic s8, output logic [63:0] d);
        reg_addr = a; reg_size8 = s8;
        #1 d = reg_rdata;
    endtask

    // Program and launch a copy; wait for the start bit to clear.
    task automatic run(input logic [63:0] s, input logic [63:0] d, input logic [63:0] n,
                       input logic [2:0] cmd);
        logic [63:0] v;
        wr(8'h80, s, 1); wr(8'h88, d, 1); wr(8'h90, n, 1); wr(8'h98, {61'b0, cmd}, 1);
        for (int k = 0; k < 5000; k++) begin
            rd(8'h98, 1, v);
            if (!v[0]) break;
            @(negedge clk);
        end
    endtask

    // Copy the whole buffer out to host 0x200 and compare with the model.
    task automatic dump(input string req);
        int m = 0;
        run(BASE, 64'h200, NB, 3'b011);
        for (int i = 0; i < NB; i++) begin
            exp_h[32'h200 + i] = exp_b[i];
            if (hmem[32'h200 + i] !== exp_b[i]) m++;
        end
        chk(m == 0, req, m, 0);
    endtask

    initial begin
        logic [63:0] v;
        int h0, i0, m;
        for (int i = 0; i < HN; i++) begin
            hmem[i] = 8'((i * 7 + 3) & 255);
            exp_h[i] = hmem[i];
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(hst_req == 0 && irq_evt == 0, "R1 outputs", {hst_req, irq_evt}, 0);
        rd(8'h80, 1, v); chk(v == 0, "R1 src", v, 0);
        rd(8'h98, 1, v); chk(v == 0, "R1 cmd", v, 0);
        rst_n = 1;
        @(negedge clk);
        // R2 halves
        wr(8'h80, 64'h1111_2222_3333_4444, 1);
        wr(8'h84, 64'hAAAA_BBBB, 0);
        rd(8'h80, 1, v); chk(v == 64'hAAAA_BBBB_3333_4444, "R2 hi write", v, 64'hAAAA_BBBB_3333_4444);
        wr(8'h80, 64'h5555_6666, 0);
        rd(8'h80, 1, v); chk(v == 64'hAAAA_BBBB_5555_6666, "R2 lo write", v, 64'hAAAA_BBBB_5555_6666);
        rd(8'h84, 0, v); chk(v == 64'hAAAA_BBBB, "R2 hi read", v, 64'hAAAA_BBBB);
        wr(8'h98, 64'h6, 1);
        rd(8'h98, 1, v); chk(v == 64'h6, "R2 cmd flags", v, 6);
        // R3 sweep: host to buffer with varied offsets and counts
        for (int i = 0; i < NB; i++) exp_b[i] = 0;
        run(64'h0, BASE, NB, 3'b001);
        for (int i = 0; i < NB; i++) exp_b[i] = exp_h[i];
        dump("R3 full fill");
        for (int k = 0; k < 6; k++) begin
            int off = (k * 11) % NB;
            int n = 1 + (k * 13) % (NB - off);
            int hs = 100 + k * 90;
            h0 = hs_cnt;
            run(64'(hs), BASE + 64'(off), 64'(n), 3'b001);
            chk(hs_cnt - h0 == n, "R10 handshakes", hs_cnt - h0, n);
            for (int i = 0; i < n; i++) exp_b[off + i] = exp_h[hs + i];
            dump("R3 partial");
        end
        // R4 buffer to host at varied offsets
        for (int k = 0; k < 4; k++) begin
            int off = k * 9;
            int n = 5 + k * 7;
            int hd = 600 + k * 50;
            run(BASE + 64'(off), 64'(hd), 64'(n), 3'b011);
            m = 0;
            for (int i = 0; i < n; i++) if (hmem[hd + i] !== exp_b[off + i]) m++;
            for (int i = 0; i < n; i++) exp_h[hd + i] = exp_b[off + i];
            chk(m == 0, "R4 copy out", m, 0);
        end
        // R5 start bit visible while running, then clear
        wr(8'h80, 64'h0, 1); wr(8'h88, BASE, 1); wr(8'h90, NB, 1);
        wr(8'h98, 64'h1, 1);
        rd(8'h98, 1, v); chk(v[0] == 1, "R5 busy", v, 1);
        // R9 writes while busy are ignored
        wr(8'h80, 64'h123, 1);
        wr(8'h98, 64'h6, 1);
        rd(8'h80, 1, v); chk(v == 0, "R9 src frozen", v, 0);
        rd(8'h98, 1, v); chk(v[2:1] == 0, "R9 cmd frozen", v, 1);
        for (int k = 0; k < 2000; k++) begin
            rd(8'h98, 1, v);
            if (!v[0]) break;
            @(negedge clk);
        end
        chk(v[0] == 0, "R5 cleared", v, 0);
        for (int i = 0; i < NB; i++) exp_b[i] = exp_h[i];
        // R6 event with and without enable
        i0 = irq_cnt;
        run(64'h10, BASE, 4, 3'b001);
        repeat (2) @(negedge clk);
        chk(irq_cnt == i0, "R6 no event", irq_cnt - i0, 0);
        for (int i = 0; i < 4; i++) exp_b[i] = exp_h[16 + i];
        run(64'h20, BASE + 4, 4, 3'b101);
        repeat (2) @(negedge clk);
        chk(irq_cnt == i0 + 1 && code_bad == 0, "R6 one event 0x100", irq_cnt - i0, 1);
        for (int i = 0; i < 4; i++) exp_b[4 + i] = exp_h[32 + i];
        // R7 device range edges
        h0 = hs_cnt; i0 = irq_cnt;
        run(64'h30, BASE + NB - 4, 5, 3'b101);
        run(64'h30, BASE - 1, 2, 3'b101);
        repeat (2) @(negedge clk);
        chk(hs_cnt == h0 && irq_cnt == i0, "R7 abort quiet", hs_cnt - h0, 0);
        run(64'h30, BASE + NB - 4, 4, 3'b001);
        for (int i = 0; i < 4; i++) exp_b[NB - 4 + i] = exp_h[48 + i];
        dump("R7 edge accepted, aborts wrote nothing");
        // R8 host limit edges
        h0 = hs_cnt; i0 = irq_cnt;
        run(64'(HN - 4), BASE, 5, 3'b101);
        run(BASE, 64'(HN), 1, 3'b111);
        repeat (2) @(negedge clk);
        chk(hs_cnt == h0 && irq_cnt == i0, "R8 abort quiet", hs_cnt - h0, 0);
        run(64'(HN - 1), BASE + 10, 1, 3'b001);
        exp_b[10] = exp_h[HN - 1];
        dump("R8 edge accepted");
        // R11 zero count
        h0 = hs_cnt; i0 = irq_cnt;
        run(64'h0, BASE, 0, 3'b101);
        repeat (2) @(negedge clk);
        chk(hs_cnt == h0 && irq_cnt == i0 + 1, "R11 zero count", hs_cnt - h0, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule